// File: doc/BRIEF.md
# Legacy Paravirtual Device Control Register File

This block is the byte-addressed control register file of a legacy paravirtual I/O device that has a small, fixed number of queues. A driver reads the feature set the device offers and writes back the features it wants. The block cleans up that request before accepting it. The driver selects a queue, reads its size and gives it a ring page number. It then moves the device status through its phases, kicks queues and takes interrupts through a status byte that clears when read.

Accesses at or above the device-specific offset are not decoded here. They are forwarded to an external configuration port, with the offset rebased to zero. The ring engines sit outside the block. They take the per-queue page numbers, the kick pulses and the reset and ready pulses, and they post interrupt causes back into the block.

Top module: `vio_regfile`

## Requirements
- R1: After reset, the accepted features, the queue selector, the status, the interrupt status and every queue page number are zero. The outputs `rd_valid`, `kick`, `dev_reset`, `drv_ready` and `irq` are low.
- R2: A read at offset 0x00 returns the parameter HOST_FEATURES ORed with bit 24 (notify when empty) and bit 30 (bad feature). Writes to 0x00 have no effect.
- R3: A write at offset 0x04 with bit 30 set makes the accepted features equal to MIN_FEATURES.
- R4: A write at 0x04 that has bit 30 clear but asks for any bit outside HOST_FEATURES|bit 24 makes the accepted features HOST_FEATURES|bit 24. Any other value is accepted as written. The accepted set reads back at 0x04 and drives `guest_features`.
- R5: A write at 0x0E uses only bits 15:0 and becomes the queue selector only if that value is below NUM_QUEUES. Otherwise the selector is unchanged. The selector reads back at 0x0E.
- R6: A nonzero write at 0x08 stores the page number for the selected queue. It reads back at 0x08 and appears on that queue's field of `queue_pfn` (queue i at bits i*PFN_W upward).
- R7: A read at 0x0C returns the 16-bit size of the selected queue from QUEUE_SIZES (queue i at bits i*16 upward).
- R8: A write of zero at 0x08 stores zero and performs a full device reset: the same clearing as R9, with one `dev_reset` pulse.
- R9: A write at 0x12 keeps bits 7:0 as the status. If those bits are zero, the features, selector, status, interrupt status and all page numbers clear, and `dev_reset` pulses for one cycle.
- R10: `drv_ready` pulses for one cycle only when a nonzero status write sets bit 2 while the stored status has bit 2 clear.
- R11: A write at 0x10 pulses `kick[n]` for one cycle, where n = bits 15:0, only if n is below NUM_QUEUES and queue n has a nonzero page number. Otherwise no kick fires.
- R12: Each `irq_cause` bit ORs into the 8-bit interrupt status, and `irq` is high while that status is nonzero. A read at 0x13 returns the status and clears it, which drops `irq`. A cause arriving in the same cycle as that read, or in the same cycle as a device reset, is kept.
- R13: An access at or above 0x14 drives `cfg_valid` in the same cycle with `cfg_offset` = address − 0x14. A read at such an offset returns `cfg_rdata`. A read of any other undecoded offset returns all ones.
- R14: Every read is answered one cycle later on `rd_valid`/`rd_data`, masked to the access size (`bus_size` 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| cfg_valid | output | 1 | Forwarded device-config access |
| cfg_write | output | 1 | Direction of forwarded access |
| cfg_offset | output | ADDR_W | Rebased config offset |
| cfg_size | output | 2 | Size of forwarded access |
| cfg_wdata | output | 32 | Write data of forwarded access |
| cfg_rdata | input | 32 | Config read data, same cycle |
| irq_cause | input | 8 | Interrupt cause bits to post |
| irq | output | 1 | Interrupt line |
| kick | output | NUM_QUEUES | One-cycle queue kick pulses |
| dev_reset | output | 1 | One-cycle device reset pulse |
| drv_ready | output | 1 | One-cycle driver-ready pulse |
| guest_features | output | 32 | Accepted feature set |
| queue_pfn | output | NUM_QUEUES*PFN_W | Page number of each queue |

## Verification
Every register effect of an access is due one cycle after the edge that samples it. This covers read data, kick, reset and ready pulses, the interrupt line and the page-number and feature outputs. Forwarded config signals are due in the same cycle as the access, before the edge. The bench drives each access at a falling edge and checks the config outputs shortly after driving. It then waits one rising edge and compares every output at the next falling edge against a behavioural model that has already applied the access. Every clock of the run is compared this way, including idle cycles.

// File: rtl/vio_pkg.sv
package vio_pkg;

   localparam int OFF_HOST_FEAT  = 'h00;
   localparam int OFF_GUEST_FEAT = 'h04;
   localparam int OFF_QPFN       = 'h08;
   localparam int OFF_QSIZE      = 'h0C;
   localparam int OFF_QSEL       = 'h0E;
   localparam int OFF_QKICK      = 'h10;
   localparam int OFF_STATUS     = 'h12;
   localparam int OFF_ISR        = 'h13;
   localparam int OFF_DEVCFG     = 'h14;

   localparam int BIT_EMPTY_NOTIFY = 24;
   localparam int BIT_BAD_FEAT     = 30;
   localparam int BIT_DRV_OK       = 2;

   typedef enum logic [1:0] {
      ACC_B1 = 2'd0,
      ACC_B2 = 2'd1,
      ACC_B4 = 2'd2,
      ACC_BX = 2'd3
   } acc_size_e;

   function automatic logic [31:0] size_mask(input logic [1:0] sz);
      case (acc_size_e'(sz))
         ACC_B1:  size_mask = 32'h0000_00FF;
         ACC_B2:  size_mask = 32'h0000_FFFF;
         default: size_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/vio_feature_neg.sv
module vio_feature_neg
   import vio_pkg::*;
#(
   parameter logic [31:0] HOST_FEATURES = 32'h0001_0023,
   parameter logic [31:0] MIN_FEATURES  = 32'h0000_0001
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic [31:0] accepted_q,
   output logic [31:0] host_offer
);

   localparam logic [31:0] FULL_SET  = HOST_FEATURES | (32'd1 << BIT_EMPTY_NOTIFY);
   localparam logic [31:0] OFFER_SET = FULL_SET | (32'd1 << BIT_BAD_FEAT);

   if (HOST_FEATURES[BIT_BAD_FEAT]) begin : g_bad_host
      $error("HOST_FEATURES must not offer the bad-feature bit");
   end
   if ((MIN_FEATURES & ~FULL_SET) != 32'd0) begin : g_bad_min
      $error("MIN_FEATURES must be a subset of the host set");
   end

   assign host_offer = OFFER_SET;

   logic [31:0] sanitised;

   always_comb begin
      if (wdata[BIT_BAD_FEAT])
         sanitised = MIN_FEATURES;
      else if ((wdata & ~FULL_SET) != 32'd0)
         sanitised = FULL_SET;
      else
         sanitised = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         accepted_q <= '0;
      else if (clr)
         accepted_q <= '0;
      else if (wr_en)
         accepted_q <= sanitised;
   end

   // R3
   bad_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr && wdata[BIT_BAD_FEAT]) |=> (accepted_q == MIN_FEATURES));

   // R4
   within_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((accepted_q & ~FULL_SET) == 32'd0));

   // R9
   feat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (accepted_q == 32'd0));

endmodule

// File: rtl/vio_queue_bank.sv
module vio_queue_bank #(
   parameter int NUM_QUEUES = 3,
   parameter int PFN_W      = 32,
   parameter int SEL_W      = 2
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        pfn_we,
   input  logic [SEL_W-1:0]            sel,
   input  logic [PFN_W-1:0]            pfn_wdata,
   input  logic                        kick_req,
   input  logic [15:0]                 kick_idx,
   output logic [NUM_QUEUES*PFN_W-1:0] pfn_flat,
   output logic [PFN_W-1:0]            sel_pfn,
   output logic [NUM_QUEUES-1:0]       kick_o
);

   logic [PFN_W-1:0] pfn_q [NUM_QUEUES];

   for (genvar i = 0; i < NUM_QUEUES; i++) begin : g_q
      logic hit;
      assign hit = (sel == SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pfn_q[i] <= '0;
         else if (clr)
            pfn_q[i] <= '0;
         else if (pfn_we && hit)
            pfn_q[i] <= pfn_wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            kick_o[i] <= 1'b0;
         else
            kick_o[i] <= kick_req && (kick_idx == 16'(i)) && (pfn_q[i] != '0);
      end

      assign pfn_flat[i*PFN_W +: PFN_W] = pfn_q[i];

      // R11
      kick_needs_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
         kick_o[i] |-> ($past(pfn_q[i]) != '0));

      // R9
      pfn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> (pfn_q[i] == '0));
   end

   always_comb begin
      sel_pfn = '0;
      for (int k = 0; k < NUM_QUEUES; k++)
         if (sel == SEL_W'(k)) sel_pfn = pfn_q[k];
   end

   // R11
   kick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(kick_o));

endmodule

// File: rtl/vio_isr_unit.sv
module vio_isr_unit (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       rd_clr,
   input  logic [7:0] cause,
   output logic [7:0] isr_q,
   output logic       irq_o
);

   logic [7:0] base;

   assign base  = (clr || rd_clr) ? 8'h00 : isr_q;
   assign irq_o = (isr_q != 8'h00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         isr_q <= 8'h00;
      else
         isr_q <= base | cause;
   end

   // R12
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && cause == 8'h00) |=> !irq_o);

   // R12
   cause_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cause != 8'h00) |=> irq_o);

endmodule

// File: rtl/vio_regfile.sv
module vio_regfile
   import vio_pkg::*;
#(
   parameter int                    NUM_QUEUES    = 3,
   parameter int                    ADDR_W        = 8,
   parameter int                    PFN_W         = 32,
   parameter logic [NUM_QUEUES*16-1:0] QUEUE_SIZES = {16'd64, 16'd128, 16'd256},
   parameter logic [31:0]           HOST_FEATURES = 32'h0001_0023,
   parameter logic [31:0]           MIN_FEATURES  = 32'h0000_0001
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_valid,
   input  logic                        bus_write,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [1:0]                  bus_size,
   input  logic [31:0]                 bus_wdata,
   output logic                        rd_valid,
   output logic [31:0]                 rd_data,
   output logic                        cfg_valid,
   output logic                        cfg_write,
   output logic [ADDR_W-1:0]           cfg_offset,
   output logic [1:0]                  cfg_size,
   output logic [31:0]                 cfg_wdata,
   input  logic [31:0]                 cfg_rdata,
   input  logic [7:0]                  irq_cause,
   output logic                        irq,
   output logic [NUM_QUEUES-1:0]       kick,
   output logic                        dev_reset,
   output logic                        drv_ready,
   output logic [31:0]                 guest_features,
   output logic [NUM_QUEUES*PFN_W-1:0] queue_pfn
);

   localparam int SEL_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;
   localparam logic [ADDR_W-1:0] A_HOST   = ADDR_W'(OFF_HOST_FEAT);
   localparam logic [ADDR_W-1:0] A_GUEST  = ADDR_W'(OFF_GUEST_FEAT);
   localparam logic [ADDR_W-1:0] A_QPFN   = ADDR_W'(OFF_QPFN);
   localparam logic [ADDR_W-1:0] A_QSIZE  = ADDR_W'(OFF_QSIZE);
   localparam logic [ADDR_W-1:0] A_QSEL   = ADDR_W'(OFF_QSEL);
   localparam logic [ADDR_W-1:0] A_QKICK  = ADDR_W'(OFF_QKICK);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
   localparam logic [ADDR_W-1:0] A_ISR    = ADDR_W'(OFF_ISR);
   localparam logic [ADDR_W-1:0] A_DEVCFG = ADDR_W'(OFF_DEVCFG);

   if (NUM_QUEUES < 1 || NUM_QUEUES > 16) begin : g_bad_nq
      $error("NUM_QUEUES must be between 1 and 16");
   end
   if (ADDR_W < 5) begin : g_bad_aw
      $error("ADDR_W must reach the config offset");
   end
   if (PFN_W < 1 || PFN_W > 32) begin : g_bad_pfn
      $error("PFN_W must fit the 32-bit data bus");
   end

   // ---------------- access decode ----------------
   logic acc_rd, acc_wr, is_cfg;
   logic wr_guest, wr_qpfn, wr_qsel, wr_kick, wr_status;
   logic status_zero, pfn_zero, dev_clr, sel_ok, isr_rd;

   assign acc_rd = bus_valid && !bus_write;
   assign acc_wr = bus_valid &&  bus_write;
   assign is_cfg = (bus_addr >= A_DEVCFG);

   assign wr_guest  = acc_wr && (bus_addr == A_GUEST);
   assign wr_qpfn   = acc_wr && (bus_addr == A_QPFN);
   assign wr_qsel   = acc_wr && (bus_addr == A_QSEL);
   assign wr_kick   = acc_wr && (bus_addr == A_QKICK);
   assign wr_status = acc_wr && (bus_addr == A_STATUS);
   assign isr_rd    = acc_rd && (bus_addr == A_ISR);

   assign status_zero = wr_status && (bus_wdata[7:0] == 8'h00);
   assign pfn_zero    = wr_qpfn && (bus_wdata[PFN_W-1:0] == '0);
   assign dev_clr     = status_zero || pfn_zero;
   assign sel_ok      = (bus_wdata[15:0] < 16'(NUM_QUEUES));

   // ---------------- config pass-through ----------------
   assign cfg_valid  = bus_valid && is_cfg;
   assign cfg_write  = bus_write;
   assign cfg_offset = bus_addr - A_DEVCFG;
   assign cfg_size   = bus_size;
   assign cfg_wdata  = bus_wdata;

   // ---------------- queue selector (variant by queue count) ----------------
   logic [SEL_W-1:0] sel_q;

   if (NUM_QUEUES == 1) begin : g_sel_fixed
      assign sel_q = '0;
   end else begin : g_sel_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_q <= '0;
         else if (dev_clr)
            sel_q <= '0;
         else if (wr_qsel && sel_ok)
            sel_q <= bus_wdata[SEL_W-1:0];
      end
   end

   // ---------------- submodules ----------------
   logic [31:0]      host_offer;
   logic [PFN_W-1:0] sel_pfn;
   logic [7:0]       isr_q;

   vio_feature_neg #(
      .HOST_FEATURES (HOST_FEATURES),
      .MIN_FEATURES  (MIN_FEATURES)
   ) u_feat (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (dev_clr),
      .wr_en      (wr_guest),
      .wdata      (bus_wdata),
      .accepted_q (guest_features),
      .host_offer (host_offer)
   );

   vio_queue_bank #(
      .NUM_QUEUES (NUM_QUEUES),
      .PFN_W      (PFN_W),
      .SEL_W      (SEL_W)
   ) u_qbank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (dev_clr),
      .pfn_we    (wr_qpfn),
      .sel       (sel_q),
      .pfn_wdata (bus_wdata[PFN_W-1:0]),
      .kick_req  (wr_kick),
      .kick_idx  (bus_wdata[15:0]),
      .pfn_flat  (queue_pfn),
      .sel_pfn   (sel_pfn),
      .kick_o    (kick)
   );

   vio_isr_unit u_isr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (dev_clr),
      .rd_clr (isr_rd),
      .cause  (irq_cause),
      .isr_q  (isr_q),
      .irq_o  (irq)
   );

   // ---------------- queue size lookup ----------------
   logic [15:0] qsize_sel;

   always_comb begin
      qsize_sel = '0;
      for (int k = 0; k < NUM_QUEUES; k++)
         if (sel_q == SEL_W'(k)) qsize_sel = QUEUE_SIZES[k*16 +: 16];
   end

   // ---------------- device status ----------------
   logic [7:0] status_q;
   logic       ready_hit;

   assign ready_hit = wr_status && (bus_wdata[7:0] != 8'h00)
                      && bus_wdata[BIT_DRV_OK] && !status_q[BIT_DRV_OK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= 8'h00;
      else if (dev_clr)
         status_q <= 8'h00;
      else if (wr_status)
         status_q <= bus_wdata[7:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_reset <= 1'b0;
         drv_ready <= 1'b0;
      end else begin
         dev_reset <= dev_clr;
         drv_ready <= ready_hit;
      end
   end

   // ---------------- read path ----------------
   logic [31:0] rd_val;

   always_comb begin
      rd_val = 32'hFFFF_FFFF;
      if (is_cfg) begin
         rd_val = cfg_rdata;
      end else begin
         case (bus_addr)
            A_HOST:   rd_val = host_offer;
            A_GUEST:  rd_val = guest_features;
            A_QPFN:   rd_val = 32'(sel_pfn);
            A_QSIZE:  rd_val = {16'h0000, qsize_sel};
            A_QSEL:   rd_val = 32'(sel_q);
            A_STATUS: rd_val = {24'h0, status_q};
            A_ISR:    rd_val = {24'h0, isr_q};
            default:  rd_val = 32'hFFFF_FFFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= acc_rd;
         if (acc_rd)
            rd_data <= rd_val & size_mask(bus_size);
      end
   end

   // R5
   sel_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(sel_q) < NUM_QUEUES));

   // R10
   ready_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_ready |-> (status_q[BIT_DRV_OK] && !$past(status_q[BIT_DRV_OK])));

   // R9
   reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_reset |-> (status_q == 8'h00 && sel_q == '0 && guest_features == 32'd0));

   // R14
   rd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(bus_valid && !bus_write));

   // R13
   cfg_only_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (bus_addr >= A_DEVCFG));

endmodule

// File: tb/vio_regfile_bench.sv
`timescale 1ns/1ps
module vio_regfile_bench;

   localparam int NQ = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        cfg_valid, cfg_write;
   logic [7:0]  cfg_offset;
   logic [1:0]  cfg_size;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic [7:0]  irq_cause = '0;
   logic        irq;
   logic [NQ-1:0] kick;
   logic        dev_reset, drv_ready;
   logic [31:0] guest_features;
   logic [NQ*32-1:0] queue_pfn;

   always #2.5 clk = ~clk;

   assign cfg_rdata = {16'hC0DE, 8'h00, cfg_offset};

   vio_regfile u_vio_regfile (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .cfg_valid(cfg_valid),
      .cfg_write(cfg_write), .cfg_offset(cfg_offset), .cfg_size(cfg_size),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_cause(irq_cause),
      .irq(irq), .kick(kick), .dev_reset(dev_reset), .drv_ready(drv_ready),
      .guest_features(guest_features), .queue_pfn(queue_pfn)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // behavioural model state
   logic [31:0] m_feat;
   int          m_sel;
   logic [7:0]  m_status;
   logic [7:0]  m_isr;
   logic [31:0] m_pfn [NQ];
   int          m_qsize [NQ] = '{256, 128, 64};
   localparam logic [31:0] FULL  = 32'h0101_0023;
   localparam logic [31:0] OFFER = 32'h4101_0023;
   localparam logic [31:0] MINF  = 32'h0000_0001;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] msk(input logic [1:0] sz);
      if (sz == 2'd0) return 32'hFF;
      if (sz == 2'd1) return 32'hFFFF;
      return 32'hFFFF_FFFF;
   endfunction

   task automatic model_reset();
      m_feat = 0; m_sel = 0; m_status = 0; m_isr = 0;
      for (int q = 0; q < NQ; q++) m_pfn[q] = 0;
   endtask

   task automatic step(input logic v, input logic w, input logic [7:0] a,
                       input logic [1:0] sz, input logic [31:0] d,
                       input logic [7:0] c, input string tag);
      logic        e_rv, e_rst, e_rdy;
      logic [31:0] e_rd;
      logic [NQ-1:0] e_kick;
      logic [31:0] rv;
      logic [7:0]  s;
      bus_valid = v; bus_write = w; bus_addr = a; bus_size = sz;
      bus_wdata = d; irq_cause = c;
      #1;
      // R13 same-cycle forwarding
      chk(tag, "cfg_valid", 32'(cfg_valid), 32'(v && a >= 8'h14));
      if (v && a >= 8'h14) begin
         chk(tag, "cfg_offset", 32'(cfg_offset), 32'(a - 8'h14));
         chk(tag, "cfg_write", 32'(cfg_write), 32'(w));
      end
      e_rv = 0; e_rd = 0; e_rst = 0; e_rdy = 0; e_kick = '0;
      if (v && !w) begin
         e_rv = 1;
         if (a >= 8'h14) rv = {16'hC0DE, 8'h00, a - 8'h14};
         else case (a)
            8'h00: rv = OFFER;
            8'h04: rv = m_feat;
            8'h08: rv = m_pfn[m_sel];
            8'h0C: rv = 32'(m_qsize[m_sel]);
            8'h0E: rv = 32'(m_sel);
            8'h12: rv = {24'h0, m_status};
            8'h13: rv = {24'h0, m_isr};
            default: rv = 32'hFFFF_FFFF;
         endcase
         e_rd = rv & msk(sz);
         if (a == 8'h13) m_isr = 0;
      end
      if (v && w) begin
         case (a)
            8'h04: begin
               if (d[30]) m_feat = MINF;
               else if ((d & ~FULL) != 0) m_feat = FULL;
               else m_feat = d;
            end
            8'h08: begin
               m_pfn[m_sel] = d;
               if (d == 0) begin model_reset(); e_rst = 1; end
            end
            8'h0E: if (d[15:0] < NQ) m_sel = int'(d[15:0]);
            8'h10: if (d[15:0] < NQ && m_pfn[d[15:0]] != 0) e_kick[d[15:0]] = 1'b1;
            8'h12: begin
               s = d[7:0];
               if (s == 0) begin model_reset(); e_rst = 1; end
               else begin
                  e_rdy = !m_status[2] && s[2];
                  m_status = s;
               end
            end
            default: ;
         endcase
      end
      m_isr = m_isr | c;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 0; bus_write = 0; irq_cause = 0;
      chk(tag, "rd_valid", 32'(rd_valid), 32'(e_rv));
      if (e_rv) chk(tag, "rd_data", rd_data, e_rd);
      chk(tag, "kick", 32'(kick), 32'(e_kick));
      chk(tag, "dev_reset", 32'(dev_reset), 32'(e_rst));
      chk(tag, "drv_ready", 32'(drv_ready), 32'(e_rdy));
      chk(tag, "irq", 32'(irq), 32'(m_isr != 0));
      chk(tag, "guest_features", guest_features, m_feat);
      for (int q = 0; q < NQ; q++)
         chk(tag, "queue_pfn", queue_pfn[q*32 +: 32], m_pfn[q]);
   endtask

   task automatic rd(input logic [7:0] a, input logic [1:0] sz, input string tag);
      step(1, 0, a, sz, 0, 0, tag);
   endtask
   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      step(1, 1, a, 2'd2, d, 0, tag);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      step(0, 0, 0, 0, 0, 0, "R1");
      rd(8'h04, 2, "R1"); rd(8'h12, 0, "R1"); rd(8'h13, 0, "R1");
      // R2 host features, write ignored
      rd(8'h00, 2, "R2");
      wr(8'h00, 32'h0000_0000, "R2");
      rd(8'h00, 2, "R2");
      // R14 size masking
      rd(8'h00, 0, "R14"); rd(8'h00, 1, "R14"); rd(8'h00, 3, "R14");
      // R4 / R3 feature negotiation
      wr(8'h04, 32'h0000_0021, "R4"); rd(8'h04, 2, "R4");
      wr(8'h04, 32'h4000_0003, "R3"); rd(8'h04, 2, "R3");
      wr(8'h04, 32'h0200_0001, "R4"); rd(8'h04, 2, "R4");
      wr(8'h04, 32'h0100_0020, "R4"); rd(8'h04, 2, "R4");
      // R7 / R5 sizes and selection
      rd(8'h0C, 1, "R7");
      wr(8'h0E, 2, "R5"); rd(8'h0C, 1, "R7"); rd(8'h0E, 1, "R5");
      wr(8'h0E, 32'h0001_0001, "R5"); rd(8'h0E, 1, "R5");
      wr(8'h0E, 3, "R5"); rd(8'h0E, 1, "R5");
      wr(8'h0E, 32'h0000_FFFF, "R5"); rd(8'h0C, 1, "R7");
      // R6 page numbers
      wr(8'h08, 32'h0000_1234, "R6"); rd(8'h08, 2, "R6");
      wr(8'h0E, 2, "R6"); wr(8'h08, 32'h0000_0055, "R6"); rd(8'h08, 2, "R6");
      // R11 kicks
      wr(8'h10, 1, "R11"); wr(8'h10, 0, "R11"); wr(8'h10, 5, "R11");
      wr(8'h10, 32'h0001_0002, "R11"); wr(8'h10, 3, "R11");
      rd(8'h10, 2, "R13");
      // R10 ready edge
      wr(8'h12, 8'h01, "R10"); wr(8'h12, 8'h05, "R10"); wr(8'h12, 8'h07, "R10");
      wr(8'h12, 32'h0000_0103, "R10"); rd(8'h12, 0, "R9");
      wr(8'h12, 8'h04, "R10");
      // R12 interrupt status
      step(0, 0, 0, 0, 0, 8'h01, "R12");
      step(0, 0, 0, 0, 0, 0, "R12");
      rd(8'h13, 0, "R12"); rd(8'h13, 0, "R12");
      step(0, 0, 0, 0, 0, 8'h02, "R12");
      step(1, 0, 8'h13, 0, 0, 8'h01, "R12");
      rd(8'h13, 0, "R12");
      // R13 config forwarding and undefined reads
      rd(8'h14, 1, "R13"); rd(8'h20, 2, "R13");
      wr(8'h18, 32'hDEAD_BEEF, "R13");
      rd(8'h02, 2, "R13"); rd(8'h11, 0, "R13"); rd(8'h0A, 1, "R13");
      wr(8'h01, 32'hFFFF_FFFF, "R13"); rd(8'h04, 2, "R13");
      // R9 status-zero reset
      step(0, 0, 0, 0, 0, 8'h04, "R9");
      wr(8'h12, 32'h0000_0F00, "R9");
      rd(8'h0E, 1, "R9"); rd(8'h08, 2, "R9"); rd(8'h13, 0, "R9");
      wr(8'h10, 1, "R9");
      // R8 page-zero reset
      wr(8'h04, 32'h0000_0003, "R8"); wr(8'h0E, 1, "R8");
      wr(8'h08, 32'h0000_0777, "R8"); wr(8'h0E, 2, "R8");
      wr(8'h08, 32'h0000_0999, "R8"); wr(8'h12, 8'h05, "R8");
      step(0, 0, 0, 0, 0, 8'h10, "R8");
      step(1, 1, 8'h08, 2, 0, 8'h20, "R8");
      rd(8'h12, 0, "R8"); rd(8'h0E, 1, "R8"); rd(8'h13, 0, "R8");
      wr(8'h10, 1, "R8");
      step(0, 0, 0, 0, 0, 0, "R1");
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule